// File: doc/BRIEF.md
# Linear Frequency Sweep Controller

This block produces the frequency tuning word that drives the phase accumulator of a direct digital synthesis core. With sweeping turned off it passes a fixed single-tone word straight through. With sweeping turned on it keeps a frequency accumulator. A rising edge on the trigger pin loads the accumulator with a start word. From then on the block adds a delta word each time a ramp-rate down counter runs out, and it stops at an end word.

Several options shape the sweep. An update strobe can restart the ramp-rate countdown in the middle of a step. Instead, the strobe can clear the accumulator for one cycle and restart the sweep from the start word. At the end of a sweep, the no-dwell option sends the output back to the start word rather than holding the end word. A static clear input holds the accumulator at zero.

The controller is built around four states:
- `S_ARMED`: waiting for a trigger; the output is the start word.
- `S_RAMP`: stepping.
- `S_DWELL`: holding the end word.
- `S_CLEAR`: accumulator at zero.

It has these transitions:
- Disable: any state to `S_ARMED`.
- Hold-clear: any state to `S_CLEAR` while the static clear is set.
- Auto-clear: any state to `S_CLEAR` on a strobe when auto-clear is set.
- Trigger: any state to `S_RAMP`.
- Release: `S_CLEAR` to `S_RAMP`.
- Finish-dwell: `S_RAMP` to `S_DWELL`.
- Finish-return: `S_RAMP` to `S_ARMED`.

Top module: `freq_sweep_ctrl`

## Requirements
- R1: While `sweep_en` is 0, `tune_word` equals `tone_word` in the same cycle, and trigger, strobe and clear inputs have no visible effect. After reset with `sweep_en` at 0, the output is `tone_word`.
- R2: After a trigger edge, the output is `start_word` and then advances by `delta_word` every `rate_val`+1 cycles. The first step appears `rate_val`+1 clock edges after the edge that took the trigger. A `rate_val` of 0 steps on every cycle.
- R3: A rising edge on `trig_in` (low at one clock edge, high at the next) restarts the sweep from `start_word` in any state. Holding `trig_in` high causes no further restart.
- R4: With `reload_on_upd` at 1, an `upd_strobe` during a sweep reloads the countdown, so the next step follows `rate_val`+1 edges after the strobe edge. With `reload_on_upd` at 0, the strobe leaves step timing unchanged.
- R5: A step that would pass `end_word` lands exactly on `end_word`. The output never exceeds `end_word` while ramping (assuming `start_word` is not above `end_word`).
- R6: With `no_dwell` at 0, the output stays at `end_word` after the sweep finishes, until a new trigger.
- R7: With `no_dwell` at 1, once the output has shown `end_word` for one step interval it returns to `start_word`. It stays there until a new trigger, which starts a new sweep.
- R8: With `autoclr_on_upd` at 1, an `upd_strobe` makes the output 0 for exactly one cycle. The output then becomes `start_word` with a fresh countdown.
- R9: While `static_clr` is 1 (and `sweep_en` is 1), the output is 0 and does not step. On release, the sweep restarts from `start_word`.
- R10: Priority from highest to lowest: sweep disable, static clear, auto-clear strobe, trigger edge, countdown reload, step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sweep_en | input | 1 | 1 selects sweeping, 0 selects the single-tone word |
| tone_word | input | 48 | Single-tone tuning word |
| start_word | input | 48 | Sweep start word |
| end_word | input | 48 | Sweep end word |
| delta_word | input | 48 | Increment per step |
| rate_val | input | 16 | Countdown value between steps |
| trig_in | input | 1 | Sweep trigger pin, rising edge starts a sweep |
| upd_strobe | input | 1 | Update strobe |
| reload_on_upd | input | 1 | Strobe reloads the countdown |
| autoclr_on_upd | input | 1 | Strobe clears and restarts the sweep |
| no_dwell | input | 1 | Return to start word when the sweep ends |
| static_clr | input | 1 | Hold the accumulator at zero |
| tune_word | output | 48 | Current tuning word |

## Verification
The properties assume three things about the inputs:
- `start_word` is not above `end_word`.
- `end_word` changes only while `sweep_en` is low.
- `start_word` is stable for the cycle that leaves the clear state.

The stimulus respects these assumptions. Every word change is made with sweeping disabled, and the sweep is then re-enabled and re-triggered. The ranges chosen keep the start below the end, and the strobes are single-cycle pulses issued between clock edges.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    typedef enum logic [1:0] {
        S_ARMED = 2'd0,
        S_RAMP  = 2'd1,
        S_DWELL = 2'd2,
        S_CLEAR = 2'd3
    } sweep_state_t;
endpackage

// File: rtl/sweep_edge_det.sv
module sweep_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin;
    end

    assign rise = pin & ~pin_q;

    // R3: a held-high pin yields a single-cycle edge only
    a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sweep_rate_timer.sv
module sweep_rate_timer #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic [RW-1:0] rate,
    output logic          tick
);
    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= rate;
        else if (run) begin
            if (cnt_q == '0) cnt_q <= rate;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = run && !load && (cnt_q == '0);
endmodule

// File: rtl/freq_sweep_ctrl.sv
module freq_sweep_ctrl
    import sweep_pkg::*;
#(
    parameter int FW = 48,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sweep_en,
    input  logic [FW-1:0] tone_word,
    input  logic [FW-1:0] start_word,
    input  logic [FW-1:0] end_word,
    input  logic [FW-1:0] delta_word,
    input  logic [RW-1:0] rate_val,
    input  logic          trig_in,
    input  logic          upd_strobe,
    input  logic          reload_on_upd,
    input  logic          autoclr_on_upd,
    input  logic          no_dwell,
    input  logic          static_clr,
    output logic [FW-1:0] tune_word
);
    localparam logic [FW-1:0] ZERO_W = '0;

    sweep_state_t  state_q, nxt_state;
    logic [FW-1:0] acc_q, nxt_acc;
    logic          tmr_load, step_tick, trig_rise;
    logic [FW-1:0] headroom;

    sweep_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (trig_in),
        .rise (trig_rise)
    );

    sweep_rate_timer #(.RW(RW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == S_RAMP),
        .load (tmr_load),
        .rate (rate_val),
        .tick (step_tick)
    );

    assign headroom = end_word - acc_q;

    always_comb begin
        nxt_state = state_q;
        nxt_acc   = acc_q;
        tmr_load  = 1'b0;
        if (!sweep_en) begin
            nxt_state = S_ARMED;
            nxt_acc   = start_word;
        end else if (static_clr) begin
            nxt_state = S_CLEAR;
            nxt_acc   = ZERO_W;
        end else if (upd_strobe && autoclr_on_upd) begin
            nxt_state = S_CLEAR;
            nxt_acc   = ZERO_W;
        end else if (trig_rise) begin
            nxt_state = S_RAMP;
            nxt_acc   = start_word;
            tmr_load  = 1'b1;
        end else begin
            unique case (state_q)
                S_ARMED, S_DWELL: begin
                end
                S_CLEAR: begin
                    nxt_state = S_RAMP;
                    nxt_acc   = start_word;
                    tmr_load  = 1'b1;
                end
                S_RAMP: begin
                    if (upd_strobe && reload_on_upd) begin
                        tmr_load = 1'b1;
                    end else if (step_tick) begin
                        if (acc_q >= end_word) begin
                            nxt_state = no_dwell ? S_ARMED : S_DWELL;
                            nxt_acc   = no_dwell ? start_word : end_word;
                        end else if (headroom <= delta_word) begin
                            nxt_acc = end_word;
                        end else begin
                            nxt_acc = acc_q + delta_word;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ARMED;
            acc_q   <= '0;
        end else begin
            state_q <= nxt_state;
            acc_q   <= nxt_acc;
        end
    end

    always_comb begin
        tune_word = sweep_en ? acc_q : tone_word;
    end

    // R5: ramping never passes the end word
    a_r5_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && state_q == S_RAMP) |-> (acc_q <= end_word));

    // R6: dwelling holds the end word
    a_r6_dwell_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && state_q == S_DWELL) |-> (acc_q == end_word));

    // R2: no step without a timer tick
    a_r2_step_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !static_clr && !upd_strobe && !trig_rise
         && state_q == S_RAMP && !step_tick) |=> $stable(acc_q));

    // R8: auto-clear zeroes the accumulator
    a_r8_autoclr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !static_clr && upd_strobe && autoclr_on_upd)
        |=> (acc_q == ZERO_W && state_q == S_CLEAR));

    // R9: static clear holds zero
    a_r9_static_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && static_clr) |=> (acc_q == ZERO_W));

    // R9: release from clear restarts at the start word
    a_r9_release_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CLEAR && sweep_en && !static_clr
         && !(upd_strobe && autoclr_on_upd))
        |=> (state_q == S_RAMP && acc_q == $past(start_word)));
endmodule

// File: tb/sim_freq_sweep_ctrl.sv
module sim_freq_sweep_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sweep_en = 1'b0;
    logic [47:0] tone_word = 48'h1234_5678_9ABC;
    logic [47:0] start_word = '0, end_word = '0, delta_word = '0;
    logic [15:0] rate_val = '0;
    logic        trig_in = 1'b0, upd_strobe = 1'b0;
    logic        reload_on_upd = 1'b0, autoclr_on_upd = 1'b0;
    logic        no_dwell = 1'b0, static_clr = 1'b0;
    logic [47:0] tune_word;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    freq_sweep_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .tone_word(tone_word),
        .start_word(start_word), .end_word(end_word), .delta_word(delta_word),
        .rate_val(rate_val), .trig_in(trig_in), .upd_strobe(upd_strobe),
        .reload_on_upd(reload_on_upd), .autoclr_on_upd(autoclr_on_upd),
        .no_dwell(no_dwell), .static_clr(static_clr), .tune_word(tune_word)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [47:0] exp);
        #0;
        checks++;
        if (tune_word !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, tune_word, exp);
        end
    endtask

    task automatic setup(input logic [47:0] s, input logic [47:0] e,
                         input logic [47:0] d, input logic [15:0] r);
        sweep_en = 1'b0;
        start_word = s; end_word = e; delta_word = d; rate_val = r;
        cyc(1);
        sweep_en = 1'b1;
        cyc(1);
    endtask

    task automatic t_tone();
        chk("R1 reset tone", 48'h1234_5678_9ABC);
        trig_in = 1'b1; upd_strobe = 1'b1; autoclr_on_upd = 1'b1;
        cyc(2);
        chk("R1 inputs ignored", 48'h1234_5678_9ABC);
        trig_in = 1'b0; upd_strobe = 1'b0; autoclr_on_upd = 1'b0;
        tone_word = 48'd777;
        cyc(1);
        chk("R1 follows tone", 48'd777);
    endtask

    task automatic t_basic();
        setup(100, 160, 20, 2);
        chk("R3 armed at start", 100);
        trig_in = 1'b1;
        cyc(1); chk("R2 start after trigger", 100);
        cyc(2); chk("R2 before first step", 100);
        cyc(1); chk("R2 first step", 120);
        cyc(3); chk("R2 second step", 140);
        cyc(3); chk("R2 third step", 160);
        cyc(10); chk("R6 dwell, R3 held high no restart", 160);
        trig_in = 1'b0;
        cyc(1); chk("R6 dwell after trigger low", 160);
        trig_in = 1'b1;
        cyc(1); chk("R3 retrigger from dwell", 100);
        trig_in = 1'b0;
        cyc(1);
    endtask

    task automatic t_saturate();
        setup(100, 160, 25, 2);
        trig_in = 1'b1;
        cyc(1); chk("R5 start", 100);
        cyc(3); chk("R5 step1", 125);
        cyc(3); chk("R5 step2", 150);
        cyc(3); chk("R5 saturate at end", 160);
        cyc(3); chk("R5 stays at end", 160);
        trig_in = 1'b0;
        cyc(1);
    endtask

    task automatic t_nodwell();
        no_dwell = 1'b1;
        setup(100, 160, 20, 0);
        trig_in = 1'b1;
        cyc(1); chk("R2 rate0 start", 100);
        cyc(1); chk("R2 rate0 every cycle", 120);
        cyc(1); chk("R2 rate0 second", 140);
        cyc(1); chk("R7 end shown", 160);
        cyc(1); chk("R7 return to start", 100);
        cyc(5); chk("R7 parked at start", 100);
        trig_in = 1'b0;
        cyc(1);
        trig_in = 1'b1;
        cyc(1); chk("R7 new sweep start", 100);
        cyc(1); chk("R7 new sweep steps", 120);
        trig_in = 1'b0; no_dwell = 1'b0;
        cyc(1);
    endtask

    task automatic t_reload_autoclr();
        setup(100, 1000, 10, 3);
        trig_in = 1'b1;
        cyc(1); chk("R4 start", 100);
        cyc(4); chk("R4 first step", 110);
        cyc(1);
        upd_strobe = 1'b1; reload_on_upd = 1'b1;
        cyc(1);
        upd_strobe = 1'b0; reload_on_upd = 1'b0;
        cyc(2); chk("R4 reload delays step", 110);
        cyc(2); chk("R4 step after reload", 120);
        cyc(1);
        upd_strobe = 1'b1;
        cyc(1);
        upd_strobe = 1'b0;
        cyc(1); chk("R4 strobe without option", 120);
        cyc(1); chk("R4 timing unchanged", 130);
        upd_strobe = 1'b1; autoclr_on_upd = 1'b1;
        cyc(1); chk("R8 cleared one cycle", 0);
        upd_strobe = 1'b0; autoclr_on_upd = 1'b0;
        cyc(1); chk("R8 restart at start", 100);
        cyc(3); chk("R8 fresh countdown", 100);
        cyc(1); chk("R8 step after restart", 110);
        trig_in = 1'b0;
        cyc(1);
    endtask

    task automatic t_static();
        setup(100, 1000, 10, 1);
        trig_in = 1'b1;
        cyc(1); chk("R9 start", 100);
        cyc(2); chk("R9 step", 110);
        static_clr = 1'b1;
        cyc(1); chk("R9 held zero", 0);
        trig_in = 1'b0;
        cyc(1);
        trig_in = 1'b1;
        cyc(2); chk("R10 clear beats trigger", 0);
        sweep_en = 1'b0;
        cyc(1); chk("R10 disable beats clear", 48'd777);
        sweep_en = 1'b1;
        cyc(1); chk("R9 clear on re-enable", 0);
        static_clr = 1'b0;
        cyc(1); chk("R9 release to start", 100);
        cyc(2); chk("R9 steps after release", 110);
        trig_in = 1'b0;
        cyc(1);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        t_tone();
        t_basic();
        t_saturate();
        t_nodwell();
        t_reload_autoclr();
        t_static();
        finish_run();
    end
endmodule